// File: doc/BRIEF.md
# Nibble-Bus Expander Host Sequencer

This block is a clocked master for a 4-bit port expander that sits on a shared nibble bus. A host hands it one command at a time. The command gives a direction, one of four port indices and a write nibble. The block then plays a fixed script of control words on an 8-bit control output. Each word carries the bus nibble, an enable for the external bus driver, the strobe line (PROG) and an active-low chip select. This is the same handshake that driver software would bit-bang through a PC parallel port.

During a read, the block releases the bus driver so that the expander can answer. It samples a 4-bit status nibble and returns that value with its top bit inverted. Every script step is held for `STEP_TICKS` clock cycles, so the bus timing can be stretched to suit slow parts. A one-cycle done pulse marks the end of every transaction.

Top module: `nbx_host`

## Requirements
- R1: After reset and whenever idle, `ctrl_word` is 8'h60: bus nibble zero (bits 3..0), driver enable off (bit 4), PROG high (bit 5), chip select deasserted high (bit 6), bit 7 zero. `ready` is 1 and `done` is 0.
- R2: The command nibble sent on the bus is `port + 4` for a write and `port` for a read, where port is 0..3.
- R3: A write plays five words in order: 8'h30|cmd, 8'h10|cmd, 8'h10|data, 8'h30|data, 8'h70.
- R4: A read plays four words in order: 8'h30|cmd, 8'h10|cmd, 8'h00, 8'h60.
- R5: `rd_data` is loaded with `status_in` XOR 4'b1000 on the last clock of the third read word (8'h00). A status change earlier in that word has no effect.
- R6: Each script word stays on `ctrl_word` for exactly `STEP_TICKS` cycles. The first word appears in the cycle after the command is accepted.
- R7: A command is taken only when `cmd_valid` and `ready` are both 1. A command presented while busy is ignored and does not change the script that is running.
- R8: `done` is high for exactly one cycle, the cycle right after the last word. In that cycle `ready` is 1 again and `ctrl_word` is back at 8'h60.
- R9: `rd_data` keeps its value until the next read captures a new one. Writes leave it unchanged.
- R10: Throughout every word of a write, bit 4 (driver enable) of `ctrl_word` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_port | input | 2 | Expander port index 0..3 |
| cmd_data | input | 4 | Nibble to write |
| ready | output | 1 | Idle, able to take a command |
| ctrl_word | output | 8 | Control word: nibble, driver enable, PROG, chip select (active low) |
| status_in | input | 4 | Status nibble read back from the bus |
| rd_data | output | 4 | Read result, status with top bit inverted |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The command is accepted at edge E0. Script word k is then on `ctrl_word` during cycles k*STEP_TICKS through k*STEP_TICKS+STEP_TICKS-1 after E0. `done`, `ready` and the new `rd_data` are all due in cycle N*STEP_TICKS, where N is 5 for a write and 4 for a read. The bench drives and samples on the falling edge, and it counts falling edges from the acceptance edge. It checks `ctrl_word` on every tick of every word, then checks the done cycle and the cycle after it. For the sampling rule, the status value is changed on the falling edge just before the capture edge, so only a capture on that final tick returns the late value.

// File: rtl/nbx_pkg.sv
package nbx_pkg;
  localparam int CW_W   = 8;
  localparam int NIB_W  = 4;
  localparam int PORT_W = 2;

  localparam int B_OE   = 4;
  localparam int B_PROG = 5;
  localparam int B_CSN  = 6;

  localparam int STEP_W = 3;
  typedef logic [STEP_W-1:0] step_t;

  localparam step_t WR_LAST   = 3'd4;
  localparam step_t RD_LAST   = 3'd3;
  localparam step_t RD_SAMPLE = 3'd2;

  // Command nibble: a write sets bit 2 (port + 4), a read sends the port alone.
  function automatic logic [NIB_W-1:0] instr_code(input logic wr, input logic [PORT_W-1:0] port);
    return {1'b0, wr, port};
  endfunction

  function automatic logic [CW_W-1:0] ctrl_pack(input logic [NIB_W-1:0] nib, input logic oe,
                                                input logic prog, input logic csn);
    logic [CW_W-1:0] w;
    w          = '0;
    w[NIB_W-1:0] = nib;
    w[B_OE]    = oe;
    w[B_PROG]  = prog;
    w[B_CSN]   = csn;
    return w;
  endfunction

  function automatic logic [NIB_W-1:0] readback(input logic [NIB_W-1:0] s);
    return s ^ {1'b1, {(NIB_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/nbx_step_timer.sv
module nbx_step_timer #(
  parameter int STEP_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic step_end
);
  localparam int TICK_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(STEP_TICKS - 1);

  logic [TICK_W-1:0] cnt;

  assign step_end = busy && (cnt == TICK_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!busy || step_end) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nbx_script_fsm.sv
module nbx_script_fsm
  import nbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  is_write,
  input  logic  step_end,
  output logic  busy,
  output step_t step,
  output logic  last_end,
  output logic  done
);
  step_t last_idx;

  assign last_idx = is_write ? WR_LAST : RD_LAST;
  assign last_end = busy && step_end && (step == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
      end else if (last_end) begin
        busy <= 1'b0;
        step <= '0;
        done <= 1'b1;
      end else if (busy && step_end) begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nbx_word_gen.sv
module nbx_word_gen
  import nbx_pkg::*;
(
  input  logic              busy,
  input  logic              is_write,
  input  step_t             step,
  input  logic [NIB_W-1:0]  instr,
  input  logic [NIB_W-1:0]  wdata,
  output logic [CW_W-1:0]   ctrl_word
);
  always_comb begin
    ctrl_word = ctrl_pack('0, 1'b0, 1'b1, 1'b1);
    if (busy) begin
      if (is_write) begin
        case (step)
          3'd0:    ctrl_word = ctrl_pack(instr, 1'b1, 1'b1, 1'b0);
          3'd1:    ctrl_word = ctrl_pack(instr, 1'b1, 1'b0, 1'b0);
          3'd2:    ctrl_word = ctrl_pack(wdata, 1'b1, 1'b0, 1'b0);
          3'd3:    ctrl_word = ctrl_pack(wdata, 1'b1, 1'b1, 1'b0);
          default: ctrl_word = ctrl_pack('0,    1'b1, 1'b1, 1'b1);
        endcase
      end else begin
        case (step)
          3'd0:    ctrl_word = ctrl_pack(instr, 1'b1, 1'b1, 1'b0);
          3'd1:    ctrl_word = ctrl_pack(instr, 1'b1, 1'b0, 1'b0);
          3'd2:    ctrl_word = ctrl_pack('0,    1'b0, 1'b0, 1'b0);
          default: ctrl_word = ctrl_pack('0,    1'b0, 1'b1, 1'b1);
        endcase
      end
    end
  end
endmodule

// File: rtl/nbx_host.sv
module nbx_host
  import nbx_pkg::*;
#(
  parameter int STEP_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [PORT_W-1:0] cmd_port,
  input  logic [NIB_W-1:0]  cmd_data,
  output logic              ready,
  output logic [CW_W-1:0]   ctrl_word,
  input  logic [NIB_W-1:0]  status_in,
  output logic [NIB_W-1:0]  rd_data,
  output logic              done
);
  logic              busy;
  logic              accept;
  logic              step_end;
  logic              last_end;
  logic              rd_capture;
  logic              busy_write;
  step_t             step;
  logic              lat_write;
  logic [NIB_W-1:0]  lat_instr;
  logic [NIB_W-1:0]  lat_data;

  assign ready      = !busy;
  assign accept     = cmd_valid && ready;
  assign busy_write = busy && lat_write;
  assign rd_capture = busy && !lat_write && (step == RD_SAMPLE) && step_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      lat_instr <= '0;
      lat_data  <= '0;
    end else if (accept) begin
      lat_write <= cmd_write;
      lat_instr <= instr_code(cmd_write, cmd_port);
      lat_data  <= cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data <= '0;
    else if (rd_capture) rd_data <= readback(status_in);
  end

  nbx_step_timer #(.STEP_TICKS(STEP_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .step_end (step_end)
  );

  nbx_script_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .is_write (lat_write),
    .step_end (step_end),
    .busy     (busy),
    .step     (step),
    .last_end (last_end),
    .done     (done)
  );

  nbx_word_gen u_words (
    .busy      (busy),
    .is_write  (lat_write),
    .step      (step),
    .instr     (lat_instr),
    .wdata     (lat_data),
    .ctrl_word (ctrl_word)
  );
endmodule

// File: rtl/nbx_host_chk.sv
module nbx_host_chk
  import nbx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             ready,
  input logic             done,
  input logic [CW_W-1:0]  ctrl_word,
  input logic [NIB_W-1:0] status_in,
  input logic [NIB_W-1:0] rd_data,
  input logic             busy_write,
  input logic             step_end,
  input logic             last_end,
  input logic             rd_capture
);
  assert_idle_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ctrl_word == 8'h60));

  assert_step_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !step_end) |=> $stable(ctrl_word));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && cmd_valid && !last_end) |=> !ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_end |=> (done && ready));

  assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> (rd_data == ($past(status_in) ^ 4'h8)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rd_data));

  assert_write_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_write |-> ctrl_word[B_OE]);
endmodule

bind nbx_host nbx_host_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .ready      (ready),
  .done       (done),
  .ctrl_word  (ctrl_word),
  .status_in  (status_in),
  .rd_data    (rd_data),
  .busy_write (busy_write),
  .step_end   (step_end),
  .last_end   (last_end),
  .rd_capture (rd_capture)
);

// File: tb/tb_nbx_host.sv
module tb_nbx_host;
  localparam int STEP_TICKS = 4;
  localparam int NV = 8;
  // {write, port[1:0], data[3:0], status_early[3:0], status_late[3:0]}
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 2'd0, 4'hF, 4'h0, 4'h0},
    {1'b0, 2'd1, 4'h0, 4'h3, 4'h3},
    {1'b1, 2'd3, 4'h5, 4'h0, 4'h0},
    {1'b0, 2'd2, 4'h0, 4'hF, 4'h8},
    {1'b1, 2'd1, 4'hA, 4'h0, 4'h0},
    {1'b0, 2'd3, 4'h0, 4'h0, 4'h7},
    {1'b1, 2'd2, 4'h0, 4'h0, 4'h0},
    {1'b0, 2'd0, 4'h0, 4'h9, 4'h1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [1:0] cmd_port = '0;
  logic [3:0] cmd_data = '0;
  logic [3:0] status_in = '0;
  logic       ready;
  logic [7:0] ctrl_word;
  logic [3:0] rd_data;
  logic       done;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_rd = 4'h0;

  always #10 clk = ~clk;

  nbx_host #(.STEP_TICKS(STEP_TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_port(cmd_port), .cmd_data(cmd_data), .ready(ready), .ctrl_word(ctrl_word),
    .status_in(status_in), .rd_data(rd_data), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input bit wr, input logic [1:0] p,
                                          input logic [3:0] d, input int k);
    logic [7:0] ins;
    ins = wr ? (8'(p) + 8'd4) : 8'(p);
    if (wr) begin
      case (k)
        0: return 8'h30 + ins;
        1: return 8'h10 + ins;
        2: return 8'h10 + 8'(d);
        3: return 8'h30 + 8'(d);
        default: return 8'h70;
      endcase
    end else begin
      case (k)
        0: return 8'h30 + ins;
        1: return 8'h10 + ins;
        2: return 8'h00;
        default: return 8'h60;
      endcase
    end
  endfunction

  task automatic run_txn(input bit wr, input logic [1:0] p, input logic [3:0] d,
                         input logic [3:0] s_early, input logic [3:0] s_late, input bit poke);
    int nsteps;
    bit first;
    nsteps = wr ? 5 : 4;
    @(negedge clk);
    check("R7 ready before command", ready, 1'b1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_port = p; cmd_data = d; status_in = s_early;
    @(negedge clk);
    if (poke) begin
      cmd_write = ~wr; cmd_port = ~p; cmd_data = ~d;
    end else begin
      cmd_valid = 1'b0;
    end
    first = 1'b1;
    for (int k = 0; k < nsteps; k++) begin
      for (int t = 0; t < STEP_TICKS; t++) begin
        if (!first) @(negedge clk);
        first = 1'b0;
        check(t == 0 ? (wr ? "R3/R2 write word" : "R4/R2 read word") : "R6 word held",
              ctrl_word, exp_word(wr, p, d, k));
        check(poke ? "R7 busy while command offered" : "R7 busy", ready, 1'b0);
        check("R8 no early done", done, 1'b0);
        if (wr) check("R10 driver on in write", ctrl_word[4], 1'b1);
        if (!wr && k == 2 && t == STEP_TICKS - 1) status_in = s_late;
        if (poke && k == nsteps - 1 && t == STEP_TICKS - 1) cmd_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R8 done pulse", done, 1'b1);
    check("R8 ready at done", ready, 1'b1);
    check("R1 idle word at done", ctrl_word, 8'h60);
    if (!wr) begin
      exp_rd = s_late ^ 4'h8;
      check("R5 read data", rd_data, exp_rd);
    end else begin
      check("R9 read data kept over write", rd_data, exp_rd);
    end
    @(negedge clk);
    check("R8 done one cycle", done, 1'b0);
    check("R9 read data held", rd_data, exp_rd);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", ctrl_word, 8'h60);
    check("R1 reset ready", ready, 1'b1);
    check("R1 reset done", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle word", ctrl_word, 8'h60);

    for (int i = 0; i < NV; i++)
      run_txn(VEC[i][14], VEC[i][13:12], VEC[i][11:8], VEC[i][7:4], VEC[i][3:0], 1'b0);

    // R7: command held valid with other fields while busy
    run_txn(1'b1, 2'd2, 4'h6, 4'h0, 4'h0, 1'b1);
    run_txn(1'b0, 2'd1, 4'h0, 4'hC, 4'h2, 1'b1);

    // R9: several idle cycles do not disturb read data
    repeat (5) @(negedge clk);
    check("R9 read data idle hold", rd_data, exp_rd);
    check("R1 idle stays", ctrl_word, 8'h60);

    // R1: reset in the middle of a write returns to idle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_port = 2'd3; cmd_data = 4'h9;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 busy before reset", ready, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 word after mid reset", ctrl_word, 8'h60);
    check("R1 ready after mid reset", ready, 1'b1);
    check("R1 read data cleared", rd_data, 4'h0);
    exp_rd = 4'h0;
    rst_n = 1'b1;
    run_txn(1'b0, 2'd3, 4'h0, 4'h5, 4'h5, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule